// File: doc/BRIEF.md
# Prioritised External Interrupt Arbiter

This block sits between a set of level-sensitive interrupt lines and one processor core. Every line carries a priority from 0 to 7, set by software, plus an enable bit. A single threshold sets the minimum urgency that may reach the core. Each cycle the block looks at the lines that are requesting, enabled, not already being serviced and above the threshold. If any line qualifies, it raises one supervisor-level external interrupt output.

The handler reads a claim register to learn which line to service. That read returns the identity of the winning line and marks it as in service, so it cannot be handed out a second time. When the handler is finished, it writes the same identity back to the claim register. That write releases the line, and if its request is still high it becomes eligible again.

Software reaches the block through a plain register port. Each access is a one-cycle write or read strobe, and read data is registered. The address map uses word addresses:
- Priority of source n (n from 1 to NUM_SRC) is at address n, in the low 3 bits.
- The enable mask is at 0x40.
- The threshold is at 0x80.
- The claim/complete register is at 0xC0.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every priority, every enable bit and the threshold are 0. No source is in service, `ext_irq_o` is 0 and `reg_rdata_o` is 0.
- R2: A source is eligible when all four of these hold:
  - its request line has been high for at least one clock edge;
  - its enable bit is set (bit k of the word at 0x40 enables source k+1, which is input bit k);
  - it is not in service;
  - its priority is above the threshold.
  `ext_irq_o` is high exactly when at least one source is eligible.
- R3: The threshold comparison is strict. A source whose priority equals the threshold is never forwarded. Priority 0 therefore never interrupts, and a threshold of 7 blocks every source.
- R4: Among eligible sources, the one with the largest priority value wins. When priorities tie, the lowest source ID wins.
- R5: A read of 0xC0 returns the winning source ID on `reg_rdata_o` in the cycle after the read strobe. The same read puts that source in service.
- R6: While a source is in service it is not delivered again, even if its request line stays high.
- R7: A read of 0xC0 with no eligible source returns 0 (ID 0 is reserved) and changes no state.
- R8: A write of an in-service source ID to 0xC0 releases that source. If its request is still high, it is eligible again after that write edge.
- R9: A write to 0xC0 of an ID that is not in service (including 0 and IDs above NUM_SRC) has no effect.
- R10: Priority, enable and threshold registers read back what was written. A priority change takes effect on the next arbitration, without any other action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Level interrupt requests, bit k is source k+1 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| ext_irq_o | output | 1 | External interrupt request to the core |

## Verification
The bench goes after the tie between equal priorities. A design that chose the highest ID there would return 3 instead of 2 when sources 2 and 3 both have priority 5.

It checks the threshold edge, where priority equal to the threshold must stay silent. A comparison using greater-or-equal would forward the request.

It holds a claimed line high to catch a gateway that re-latches an in-service source; such a design would deliver the same ID twice. It then completes a wrong ID to show that an unchecked release would reopen delivery.

Finally, it changes a priority while two requests wait, to expose a design that only samples priorities at request time.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
   // Top two address bits select the register group.
   typedef enum logic [1:0] {
      RG_PRIO  = 2'b00,
      RG_EN    = 2'b01,
      RG_THR   = 2'b10,
      RG_CLAIM = 2'b11
   } reg_grp_e;

   function automatic int unsigned max_int(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/irqarb_regs.sv
module irqarb_regs
   import irqarb_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned LOW_W   = max_int(NUM_SRC, PRIO_W)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [LOW_W-1:0]          wdata_i,
   output logic [NUM_SRC*PRIO_W-1:0] prio_o,
   output logic [NUM_SRC-1:0]        en_o,
   output logic [PRIO_W-1:0]         thr_o,
   output logic [DATA_W-1:0]         rd_val_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   reg_grp_e            grp;
   logic [IDX_W-1:0]    idx;
   logic [NUM_SRC-1:0]  en_q;
   logic [PRIO_W-1:0]   thr_q;

   assign grp = reg_grp_e'(addr_i[ADDR_W-1 -: 2]);
   assign idx = addr_i[IDX_W-1:0];

   // One priority register per source; ID g+1 sits at index g+1.
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
      logic [PRIO_W-1:0] p_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            p_q <= '0;
         else if (wr_i && grp == RG_PRIO && idx == IDX_W'(g + 1))
            p_q <= wdata_i[PRIO_W-1:0];
      end
      assign prio_o[g*PRIO_W +: PRIO_W] = p_q;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q  <= '0;
         thr_q <= '0;
      end else if (wr_i) begin
         if (grp == RG_EN)  en_q  <= wdata_i[NUM_SRC-1:0];
         if (grp == RG_THR) thr_q <= wdata_i[PRIO_W-1:0];
      end
   end

   always_comb begin
      rd_val_o = '0;
      unique case (grp)
         RG_PRIO: begin
            for (int g = 0; g < NUM_SRC; g++)
               if (idx == IDX_W'(g + 1))
                  rd_val_o = DATA_W'(prio_o[g*PRIO_W +: PRIO_W]);
         end
         RG_EN:    rd_val_o = DATA_W'(en_q);
         RG_THR:   rd_val_o = DATA_W'(thr_q);
         default:  rd_val_o = '0;
      endcase
   end

   assign en_o  = en_q;
   assign thr_o = thr_q;
endmodule

// File: rtl/irqarb_gateway.sv
module irqarb_gateway #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] claim_i,
   input  logic [NUM_SRC-1:0] done_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] busy_o
);
   // Per source: a pending flag that tracks the level while idle,
   // and a busy flag held from claim until a matching completion.
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic busy_q, busy_nxt, pend_q;

      always_comb begin
         busy_nxt = busy_q;
         if (claim_i[g])
            busy_nxt = 1'b1;
         else if (done_i[g] && busy_q)
            busy_nxt = 1'b0;
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            busy_q <= busy_nxt;
            pend_q <= req_i[g] & ~busy_nxt;
         end
      end

      assign pend_o[g] = pend_q;
      assign busy_o[g] = busy_q;
   end
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ID_W    = $clog2(NUM_SRC + 1)
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         thr_i,
   output logic [ID_W-1:0]           win_id_o
);
   logic [PRIO_W-1:0] best_p;

   // Starting the running best at the threshold gives the strict
   // comparison; strict '>' keeps the lowest ID on ties.
   always_comb begin
      best_p   = thr_i;
      win_id_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && prio_i[i*PRIO_W +: PRIO_W] > best_p) begin
            best_p   = prio_i[i*PRIO_W +: PRIO_W];
            win_id_o = ID_W'(i + 1);
         end
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irqarb_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               reg_wr_i,
   input  logic               reg_rd_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               ext_irq_o
);
   localparam int unsigned ID_W  = $clog2(NUM_SRC + 1);
   localparam int unsigned LOW_W = max_int(NUM_SRC, PRIO_W);

   if (NUM_SRC < 1 || NUM_SRC > (1 << (ADDR_W - 2)) - 1) begin : g_bad_src
      $error("NUM_SRC must fit the priority address window");
   end
   if (LOW_W > DATA_W || ID_W > DATA_W) begin : g_bad_data
      $error("DATA_W too narrow for enable mask or IDs");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic [NUM_SRC*PRIO_W-1:0] prio;
   logic [NUM_SRC-1:0]        en, pend, busy, claim_v, done_v;
   logic [PRIO_W-1:0]         thr;
   logic [DATA_W-1:0]         rd_val, rdata_q;
   logic [ID_W-1:0]           win_id;
   logic                      claim_rd, done_wr;

   assign claim_rd = reg_rd_i && reg_grp_e'(reg_addr_i[ADDR_W-1 -: 2]) == RG_CLAIM;
   assign done_wr  = reg_wr_i && reg_grp_e'(reg_addr_i[ADDR_W-1 -: 2]) == RG_CLAIM;

   irqarb_regs #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .LOW_W(LOW_W)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i[LOW_W-1:0]),
      .prio_o  (prio),
      .en_o    (en),
      .thr_o   (thr),
      .rd_val_o(rd_val)
   );

   irqarb_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
      .req_i   (pend & en),
      .prio_i  (prio),
      .thr_i   (thr),
      .win_id_o(win_id)
   );

   // Full-width ID compare so stray upper bits never match a source.
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
      assign claim_v[g] = claim_rd && win_id == ID_W'(g + 1);
      assign done_v[g]  = done_wr && reg_wdata_i == DATA_W'(g + 1);
   end

   irqarb_gateway #(.NUM_SRC(NUM_SRC)) u_gw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (irq_src_i),
      .claim_i(claim_v),
      .done_i (done_v),
      .pend_o (pend),
      .busy_o (busy)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         rdata_q <= '0;
      else if (claim_rd)
         rdata_q <= DATA_W'(win_id);
      else if (reg_rd_i)
         rdata_q <= rd_val;
   end

   assign reg_rdata_o = rdata_q;
   assign ext_irq_o   = (win_id != '0);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned DATA_W  = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               claim_rd,
   input logic               done_wr,
   input logic [DATA_W-1:0]  wdata,
   input logic               irq,
   input logic [DATA_W-1:0]  rdata,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] busy,
   input logic [NUM_SRC-1:0] en,
   input logic [PRIO_W-1:0]  thr
);
   logic done_hits;
   always_comb begin
      done_hits = 1'b0;
      for (int g = 0; g < NUM_SRC; g++)
         if (wdata == DATA_W'(g + 1) && busy[g]) done_hits = 1'b1;
   end

   // R2: a raised interrupt needs at least one pending enabled source
   a_r2_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |-> (pend & en) != '0);

   // R3: maximum threshold silences everything
   a_r3_max_thr_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr == '1) |-> !irq);

   // R5: a claim while interrupting returns a real ID and adds one busy source
   a_r5_claim_gives_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_rd && irq && !done_wr) |=> (rdata != '0) &&
         ($countones(busy) == $countones($past(busy)) + 1));

   // R7: an empty claim returns 0 and leaves service state alone
   a_r7_empty_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_rd && !irq && !done_wr) |=> (rdata == '0) && (busy == $past(busy)));

   // R9: completing an ID that is not busy changes nothing
   a_r9_bad_done_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_wr && !claim_rd && !done_hits) |=> busy == $past(busy));
endmodule

bind irq_arbiter irq_arbiter_chk #(
   .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .claim_rd(claim_rd),
   .done_wr (done_wr),
   .wdata   (reg_wdata_i),
   .irq     (ext_irq_o),
   .rdata   (reg_rdata_o),
   .pend    (pend),
   .busy    (busy),
   .en      (en),
   .thr     (thr)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
   localparam int N = 8;
   localparam logic [7:0] A_EN = 8'h40, A_THR = 8'h80, A_CLM = 8'hC0;

   logic clk = 0, rst_n = 0;
   logic [N-1:0] src = '0;
   logic wr = 0, rd = 0;
   logic [7:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic irq;
   int checks = 0, errors = 0;
   logic [31:0] v;

   always #2.5 clk = ~clk;

   irq_arbiter #(.NUM_SRC(N)) dut (
      .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_irq_o(irq));

   // Priorities of sources 1..8: 2,5,5,7,0,3,1,7
   localparam logic [2:0] PRIO [N] = '{3'd2, 3'd5, 3'd5, 3'd7, 3'd0, 3'd3, 3'd1, 3'd7};

   // vector: request mask, enable mask, threshold, expected winner (bit k = source k+1)
   typedef struct packed { logic [7:0] req; logic [7:0] en; logic [2:0] thr; logic [3:0] exp; } vec_t;
   localparam vec_t VECS [10] = '{
      '{8'b0000_0001, 8'hFF, 3'd0, 4'd1},   // R2 single source
      '{8'b0000_0111, 8'hFF, 3'd0, 4'd2},   // R4 tie 2/3 -> lowest ID
      '{8'b0000_0110, 8'hFD, 3'd0, 4'd3},   // R2 disabled source 2 skipped
      '{8'b1000_1000, 8'hFF, 3'd0, 4'd4},   // R4 tie 4/8 at 7
      '{8'b0001_0000, 8'hFF, 3'd0, 4'd0},   // R3 priority 0 never
      '{8'b0010_0001, 8'hFF, 3'd3, 4'd0},   // R3 equal to threshold blocked
      '{8'b0010_0001, 8'hFF, 3'd2, 4'd6},   // R3 above threshold
      '{8'b1111_1111, 8'h00, 3'd0, 4'd0},   // R2 nothing enabled
      '{8'b0100_0001, 8'hFF, 3'd1, 4'd1},   // R4 prio 2 beats prio 1
      '{8'b1110_0000, 8'h60, 3'd0, 4'd6}    // R4 source 8 masked
   };

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wreg(logic [7:0] a, logic [31:0] d);
      addr = a; wdata = d; wr = 1;
      @(negedge clk);
      wr = 0;
   endtask

   task automatic rreg(logic [7:0] a, output logic [31:0] d);
      addr = a; rd = 1;
      @(negedge clk);
      rd = 0;
      d = rdata;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rdata", rdata, 0);
      rreg(8'h04, v); chk("R1 prio4", v, 0);
      rreg(A_EN, v);  chk("R1 enable", v, 0);
      rreg(A_CLM, v); chk("R1 claim empty", v, 0);

      for (int i = 0; i < N; i++) wreg(8'(i + 1), 32'(PRIO[i]));
      rreg(8'h02, v); chk("R10 prio2 readback", v, 5);
      wreg(A_THR, 3); rreg(A_THR, v); chk("R10 thr readback", v, 3);
      wreg(A_EN, 32'hA5); rreg(A_EN, v); chk("R10 enable readback", v, 32'hA5);

      foreach (VECS[k]) begin
         wreg(A_EN, 32'(VECS[k].en));
         wreg(A_THR, 32'(VECS[k].thr));
         src = VECS[k].req;
         @(negedge clk);
         chk($sformatf("R2 irq vec%0d", k), 32'(irq), 32'(VECS[k].exp != 0));
         rreg(A_CLM, v);
         chk($sformatf("R4 winner vec%0d", k), v, 32'(VECS[k].exp));
         if (VECS[k].exp != 0) wreg(A_CLM, 32'(VECS[k].exp));
         src = '0;
         @(negedge clk);
      end

      // R6 / R7 / R9 / R8 sequence on source 4
      wreg(A_EN, 32'hFF); wreg(A_THR, 0);
      src = 8'b0000_1000;
      @(negedge clk);
      rreg(A_CLM, v); chk("R5 claim id", v, 4);
      chk("R6 irq after claim", 32'(irq), 0);
      @(negedge clk);
      chk("R6 held request not redelivered", 32'(irq), 0);
      rreg(A_CLM, v); chk("R7 empty claim", v, 0);
      wreg(A_CLM, 2);
      chk("R9 wrong id ignored irq", 32'(irq), 0);
      wreg(A_CLM, 32'h104);
      chk("R9 stray upper bits ignored", 32'(irq), 0);
      rreg(A_CLM, v); chk("R9 still in service", v, 0);
      wreg(A_CLM, 4);
      chk("R8 released irq", 32'(irq), 1);
      rreg(A_CLM, v); chk("R8 reclaim", v, 4);
      wreg(A_CLM, 4);
      src = '0;
      @(negedge clk);

      // R10 runtime priority change
      src = 8'b0000_0011;
      @(negedge clk);
      wreg(8'h01, 7);
      rreg(A_CLM, v); chk("R10 raised prio wins", v, 1);
      rreg(A_CLM, v); chk("R5 next winner", v, 2);
      wreg(A_CLM, 1); wreg(A_CLM, 2);
      src = '0;
      @(negedge clk);

      // R3 threshold 7 blocks priority 7
      wreg(A_THR, 7);
      src = 8'b1000_1000;
      @(negedge clk);
      chk("R3 thr max blocks", 32'(irq), 0);
      rreg(A_CLM, v); chk("R3 thr max claim", v, 0);
      src = '0;
      @(negedge clk);
      finish_run();
   end
endmodule